// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the control registers for one bank of general-purpose pins. The bank is split into four ports of eight pins each. A plain word-addressed register bus reaches it: address, write strobe, write data, and read data that follows the address combinationally. Each port has three writable registers. One picks the pin's owner, either GPIO or an alternate function. One enables the output driver, and one holds the output level. A fourth, read-only register returns the pad levels after a two-flop synchronizer.

Each writable register has a second, masked address. A write there carries a pin-select byte next to a value byte, so software can change one pin without a read-modify-write sequence. The block drives the pad output and output-enable lines itself. A pin that is not under GPIO control passes the alternate function's output and enable straight through.

Offsets inside the bank's 256-byte window are built as follows. Bits [5:4] pick the register kind (0 owner, 1 output enable, 2 output level, 3 input). Bit 7 selects the masked alias, and bits [3:2] pick the port.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is held and after it is released, every register reads zero and every synchronizer stage is zero, so every pin is under alternate-function control.
- R2: A write to offset 0x00, 0x10 or 0x20 plus 4*n stores write-data bits [7:0] into port n's owner, output-enable or output register. A read of the same offset returns that byte in [7:0] with bits [31:8] zero, and the other ports keep their contents.
- R3: A write to offset 0x80, 0x90 or 0xA0 plus 4*n updates the same register as the offset 0x80 below it. Only the pins whose bit in write-data [15:8] is 1 take the value of the matching bit in [7:0]; all other pins keep their state.
- R4: A read of a masked offset returns the current register byte in [7:0], with bits [31:8] zero.
- R5: For a pin whose owner bit is 1 (GPIO), pad_oe equals its output-enable bit, and pad_out equals its output bit ANDed with that enable.
- R6: For a pin whose owner bit is 0, pad_out equals alt_out and pad_oe equals alt_oe for that pin.
- R7: Offset 0x30 plus 4*n reads pad_in[8n+7:8n] through two flops. A pad change becomes visible at the second rising edge after it and not at the first. Writes to this offset change nothing.
- R8: Offsets that decode to no register read zero, and writes to them change no register. These are groups 0x40 to 0x70 and 0xB0 to 0xF0, and any offset with bits [1:0] not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset inside the bank window |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels, 8 bits per port |
| pad_out | output | 32 | Level driven to the pads |
| pad_oe | output | 32 | Output-driver enable for the pads |
| alt_out | input | 32 | Alternate-function output level |
| alt_oe | input | 32 | Alternate-function output enable |

## Verification
The checker watches several behaviours on every cycle. It checks the pad mux in both ownership modes against the stored registers (R5, R6) and the two-cycle delay of the input path (R7). It confirms that a masked write leaves unselected pins untouched (R3), that writes to unmapped or input offsets leave all state unchanged (R8), and that reset clears everything (R1). Byte placement and zero upper bits on reads of plain and masked offsets (R2, R4) are visible only in the bench's sweeps. The same holds for the per-port isolation of plain writes and for the exact edge at which a pad change first appears in a read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int SLOT_W    = 2;
    localparam int MAX_PORTS = 1 << SLOT_W;

    // Register kind carried in offset bits [5:4]
    typedef enum logic [1:0] {
        KIND_CFG = 2'd0,
        KIND_OE  = 2'd1,
        KIND_OUT = 2'd2,
        KIND_IN  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic                hit;
        logic                masked;
        reg_kind_e           kind;
        logic [SLOT_W-1:0]   slot;
    } bus_access_t;

    // Split a bank offset into kind, alias flag and port slot
    function automatic bus_access_t decode_addr(input logic [ADDR_W-1:0] addr);
        bus_access_t acc;
        acc.slot   = addr[3:2];
        acc.masked = addr[7];
        acc.kind   = reg_kind_e'(addr[5:4]);
        acc.hit    = (addr[1:0] == 2'b00) && !addr[6] &&
                     !(addr[7] && (addr[5:4] == 2'd3));
        return acc;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic [NUM_PORTS-1:0] wr_cfg,
    output logic [NUM_PORTS-1:0] wr_oe,
    output logic [NUM_PORTS-1:0] wr_out,
    output logic                 masked,
    output logic                 rd_hit,
    output reg_kind_e            rd_kind,
    output logic [SLOT_W-1:0]    rd_slot
);

    bus_access_t acc;

    always_comb begin
        acc     = decode_addr(addr);
        rd_hit  = acc.hit && (int'(acc.slot) < NUM_PORTS);
        rd_kind = acc.kind;
        rd_slot = acc.slot;
        masked  = acc.masked;
        wr_cfg  = '0;
        wr_oe   = '0;
        wr_out  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (we && rd_hit && (acc.slot == SLOT_W'(p))) begin
                wr_cfg[p] = (acc.kind == KIND_CFG);
                wr_oe[p]  = (acc.kind == KIND_OE);
                wr_out[p] = (acc.kind == KIND_OUT);
            end
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int PIN_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         wr_en,
    input  logic               masked,
    input  logic [2*PIN_W-1:0] wdata,
    output logic [PIN_W-1:0]   cfg_q,
    output logic [PIN_W-1:0]   oe_q,
    output logic [PIN_W-1:0]   out_q
);

    logic [PIN_W-1:0] new_val;
    logic [PIN_W-1:0] pin_sel;

    assign new_val = wdata[PIN_W-1:0];
    assign pin_sel = wdata[2*PIN_W-1:PIN_W];

    // One slice per writable register: 0 owner, 1 enable, 2 level
    for (genvar k = 0; k < 3; k++) begin : g_reg
        logic [PIN_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en[k]) begin
                if (masked) begin
                    q <= (q & ~pin_sel) | (new_val & pin_sel);
                end else begin
                    q <= new_val;
                end
            end
        end
    end

    assign cfg_q = g_reg[0].q;
    assign oe_q  = g_reg[1].q;
    assign out_q = g_reg[2].q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cfg,
    input  logic [WIDTH-1:0] oe,
    input  logic [WIDTH-1:0] out,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_oe[i]  = cfg[i] ? oe[i] : alt_oe[i];
        assign pad_out[i] = cfg[i] ? (out[i] & oe[i]) : alt_out[i];
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PIN_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*PIN_W-1:0]   pad_in,
    output logic [NUM_PORTS*PIN_W-1:0]   pad_out,
    output logic [NUM_PORTS*PIN_W-1:0]   pad_oe,
    input  logic [NUM_PORTS*PIN_W-1:0]   alt_out,
    input  logic [NUM_PORTS*PIN_W-1:0]   alt_oe
);

    localparam int NPINS = NUM_PORTS * PIN_W;

    logic [NUM_PORTS-1:0] wr_cfg;
    logic [NUM_PORTS-1:0] wr_oe;
    logic [NUM_PORTS-1:0] wr_out;
    logic                 wr_masked;
    logic                 rd_hit;
    reg_kind_e            rd_kind;
    logic [SLOT_W-1:0]    rd_slot;

    logic [NPINS-1:0]     cfg_q;
    logic [NPINS-1:0]     oe_q;
    logic [NPINS-1:0]     out_q;
    logic [NPINS-1:0]     in_sync;

    gpio_addr_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
        .addr    (bus_addr),
        .we      (bus_we),
        .wr_cfg  (wr_cfg),
        .wr_oe   (wr_oe),
        .wr_out  (wr_out),
        .masked  (wr_masked),
        .rd_hit  (rd_hit),
        .rd_kind (rd_kind),
        .rd_slot (rd_slot)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port_regs #(.PIN_W(PIN_W)) regs_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  ({wr_out[p], wr_oe[p], wr_cfg[p]}),
            .masked (wr_masked),
            .wdata  (bus_wdata[2*PIN_W-1:0]),
            .cfg_q  (cfg_q[p*PIN_W +: PIN_W]),
            .oe_q   (oe_q[p*PIN_W +: PIN_W]),
            .out_q  (out_q[p*PIN_W +: PIN_W])
        );
    end

    gpio_in_sync #(.WIDTH(NPINS)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_pad_mux #(.WIDTH(NPINS)) mux_i (
        .cfg     (cfg_q),
        .oe      (oe_q),
        .out     (out_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Read path: selected port byte, upper bits zero
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_hit && (rd_slot == SLOT_W'(p))) begin
                case (rd_kind)
                    KIND_CFG: bus_rdata[PIN_W-1:0] = cfg_q[p*PIN_W +: PIN_W];
                    KIND_OE:  bus_rdata[PIN_W-1:0] = oe_q[p*PIN_W +: PIN_W];
                    KIND_OUT: bus_rdata[PIN_W-1:0] = out_q[p*PIN_W +: PIN_W];
                    default:  bus_rdata[PIN_W-1:0] = in_sync[p*PIN_W +: PIN_W];
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PIN_W     = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [7:0]                 bus_addr,
    input logic                       bus_we,
    input logic [31:0]                bus_wdata,
    input logic [NUM_PORTS*PIN_W-1:0] pad_in,
    input logic [NUM_PORTS*PIN_W-1:0] pad_out,
    input logic [NUM_PORTS*PIN_W-1:0] pad_oe,
    input logic [NUM_PORTS*PIN_W-1:0] alt_out,
    input logic [NUM_PORTS*PIN_W-1:0] alt_oe,
    input logic [NUM_PORTS*PIN_W-1:0] cfg_q,
    input logic [NUM_PORTS*PIN_W-1:0] oe_q,
    input logic [NUM_PORTS*PIN_W-1:0] out_q,
    input logic [NUM_PORTS*PIN_W-1:0] in_sync
);

    localparam int NPINS = NUM_PORTS * PIN_W;

    logic [NPINS-1:0] keep_mask;
    logic             masked_wr;
    logic             dead_wr;

    always_comb begin
        keep_mask = ~(NPINS'(bus_wdata[PIN_W +: PIN_W]) << (PIN_W * int'(bus_addr[3:2])));
        masked_wr = bus_we && bus_addr[7] && !bus_addr[6] &&
                    (bus_addr[5:4] != 2'd3) && (bus_addr[1:0] == 2'b00);
        dead_wr   = bus_we && (bus_addr[6] || (bus_addr[5:4] == 2'd3) ||
                    (bus_addr[1:0] != 2'b00));
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0 && oe_q == '0 && out_q == '0 && in_sync == '0));

    p_masked_keep_r3: assert property (@(posedge clk) disable iff (rst)
        masked_wr |=> ((((cfg_q ^ $past(cfg_q)) | (oe_q ^ $past(oe_q)) |
                         (out_q ^ $past(out_q))) & $past(keep_mask)) == '0));

    p_gpio_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & cfg_q) == (oe_q & cfg_q));

    p_gpio_out_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_out & cfg_q) == (out_q & oe_q & cfg_q));

    p_alt_pass_r6: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ alt_out) & ~cfg_q) == '0 && ((pad_oe ^ alt_oe) & ~cfg_q) == '0);

    p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (in_sync == $past(pad_in, 2)));

    p_dead_write_r8: assert property (@(posedge clk) disable iff (rst)
        dead_wr |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PORTS(NUM_PORTS), .PIN_W(PIN_W)) chk_i (.*);

// File: tb/gpio_bank_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb_top;

    localparam int NP = 4;
    localparam int PW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] alt_out;
    logic [31:0] alt_oe;

    int n_chk = 0;
    int n_bad = 0;

    // model: index 0 owner, 1 output enable, 2 output level
    logic [7:0] mdl [3][NP];

    always #2 clk = ~clk;

    gpio_bank_regs #(.NUM_PORTS(NP), .PIN_W(PW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] flat(input int k);
        logic [31:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = mdl[k][p];
        return v;
    endfunction

    task automatic chk_pads(input string req);
        logic [31:0] c, e, o;
        @(negedge clk);
        #1;
        c = flat(0);
        e = flat(1);
        o = flat(2);
        check({req, " pad_oe"},  pad_oe,  (c & e) | (~c & alt_oe));
        check({req, " pad_out"}, pad_out, (c & e & o) | (~c & alt_out));
    endtask

    task automatic chk_model(input string req);
        logic [31:0] d;
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < NP; p++) begin
                rd(8'(k*16 + p*4), d);
                check(req, d, {24'h0, mdl[k][p]});
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev;
        logic [7:0]  v, s, nv;
        rst = 1'b1;
        bus_addr = '0;
        bus_we = 1'b0;
        bus_wdata = '0;
        pad_in = '0;
        alt_out = '0;
        alt_oe = '0;
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < NP; p++) mdl[k][p] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset, including aliases and input
        for (int g = 0; g < 16; g++)
            for (int p = 0; p < NP; p++) begin
                rd(8'(g*16 + p*4), d);
                check("R1 reset read", d, 32'h0);
            end
        alt_out = 32'h5A3C_96E1;
        alt_oe  = 32'hC3A5_0FF0;
        chk_pads("R1 R6 reset pins follow alternate function");

        // R2: plain writes, upper data bits must not leak
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < NP; p++) begin
                v = 8'h3C ^ 8'(p*8'h51) ^ 8'(k*8'h17);
                wr(8'(k*16 + p*4), {24'hE7B1C9, v});
                mdl[k][p] = v;
                chk_model("R2 plain write");
                chk_pads("R5 R6 after plain write");
            end

        // R3/R4: sweep every select byte on every writable register
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < NP; p++)
                for (int si = 0; si < 256; si++) begin
                    s  = 8'(si);
                    nv = 8'(si*37 + p*11 + k*5);
                    alt_out = {4{s}} ^ 32'h6B2D_91F4;
                    alt_oe  = {4{nv}} ^ 32'h1E87_C05A;
                    wr(8'(8'h80 + k*16 + p*4), {16'hC35A, s, nv});
                    mdl[k][p] = (mdl[k][p] & ~s) | (nv & s);
                    rd(8'(8'h80 + k*16 + p*4), d);
                    check("R4 masked alias read", d, {24'h0, mdl[k][p]});
                    rd(8'(k*16 + p*4), d);
                    check("R3 masked write result", d, {24'h0, mdl[k][p]});
                    chk_pads("R5 R6 pad mux");
                end
        chk_model("R3 sibling ports untouched");

        // R7: latency of the synchronizer and ignored writes
        prev = pad_in;
        for (int i = 0; i < 34; i++) begin
            logic [31:0] nxt;
            nxt = (i < 32) ? (32'h1 << i) : ((i == 32) ? 32'hFFFF_FFFF : 32'h9D3E_47A2);
            @(negedge clk);
            pad_in = nxt;
            rd(8'h30, d);
            check("R7 first edge still old", d, {24'h0, prev[7:0]});
            for (int p = 0; p < NP; p++) begin
                rd(8'(8'h30 + p*4), d);
                check("R7 visible after second edge", d, {24'h0, nxt[p*8 +: 8]});
            end
            prev = nxt;
        end
        for (int p = 0; p < NP; p++) begin
            wr(8'(8'h30 + p*4), 32'hFFFF_FFFF);
            rd(8'(8'h30 + p*4), d);
            check("R7 input write ignored", d, {24'h0, prev[p*8 +: 8]});
        end
        chk_model("R7 input write leaves registers");

        // R8: unmapped groups and misaligned offsets
        for (int g = 3; g < 16; g++) begin
            if (g < 8 || g > 10) begin
                for (int p = 0; p < NP; p++) begin
                    wr(8'(g*16 + p*4), 32'hFFFF_FFFF);
                    if (g != 3) begin
                        rd(8'(g*16 + p*4), d);
                        check("R8 unmapped read zero", d, 32'h0);
                    end
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            for (int lo = 1; lo < 4; lo++) begin
                wr(8'(p*4 + lo), 32'hFFFF_FFFF);
                wr(8'(8'hA0 + p*4 + lo), 32'hFFFF_FFFF);
                rd(8'(8'h20 + p*4 + lo), d);
                check("R8 misaligned read zero", d, 32'h0);
            end
        end
        chk_model("R8 dead writes change nothing");
        chk_pads("R8 pads after dead writes");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule